// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block runs single clause-22 management transactions to an external PHY. Software writes one 32-bit word into the frame register. That word holds the start code, opcode, PHY address, register address, turnaround code and 16-bit data. The write launches a frame at once. The controller derives a slow management clock from the system clock and drives and samples the shared data line through separate out, enable and in signals. It sends a 32-bit preamble of ones, followed by the written word with the most significant bit first.

For a read, the line is released during the second turnaround bit and the sixteen data bits. The bits sampled from the PHY replace the low half of the frame register. When the frame ends, a done flag is set in the event register. Software can poll that flag or, when the mask bit allows it, see it as an interrupt.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A bus write to address 0 (frame) while idle with a nonzero divider starts a frame. The frame is 32 ones, then bits 31 down to 0 of the written word. `mdio_o` changes only on the edge where `mdc` falls, or on the start edge, never where `mdc` rises.
- R2: With divider value N, `mdc` goes high N cycles after the start edge, falls N cycles later, and repeats with period 2N. `mdc` is low whenever no frame runs.
- R3: In a write frame (bits 29:28 = 01), `mdio_oe` stays high for all 64 bits and the data field goes out unchanged. The frame register keeps the written word.
- R4: In a read frame (bits 29:28 = 10), `mdio_oe` is low for bit positions 47 to 63 (counting the first preamble bit as 0). `mdio_i` is sampled at each rising `mdc` of positions 48 to 63, most significant bit first. The result replaces frame bits 15:0, and bits 31:16 are kept.
- R5: A frame lasts 128N cycles. On the edge that ends it, `mdc` and `mdio_oe` go low, and event bit 0 is set in that same cycle.
- R6: Writing address 2 with bit 0 = 1 clears the done flag, and writing bit 0 = 0 leaves it as it is. If a clear arrives on the completion edge, the flag stays set.
- R7: `irq` equals event bit 0 AND mask bit 0 (address 3) in every cycle. With the mask at 0, the flag is still set and readable.
- R8: With the divider (address 1, low 8 bits) at 0, a frame register write stores the word but starts no frame: `mdc` stays low and no done flag is set.
- R9: A frame register write during a running frame is dropped. Neither the register contents nor the running frame change.
- R10: Register map: 0 frame, 1 divider, 2 event, 3 mask. A read strobe returns, on the next cycle, the value the register held before the edge.
- R11: After reset, all registers read 0 and `mdc`, `mdio_oe` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input value |
| irq | output | 1 | Masked completion interrupt |

## Verification
Two events can land on the same clock edge: the frame completion setting the done flag, and a software write-one that clears it. The bench starts a frame with a divider of 1 and counts bus cycles so that the clear write is sampled exactly on edge 128 after the start. It then reads the event register and expects the flag still set, while the cycle model compares `irq` with the mask held at 0. A second coincidence is a frame write arriving in the middle of a frame. It is judged by reading the frame register afterwards and by seeing the completion at its original cycle.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BUS_AW     = 2;
  localparam int WORD_W     = 32;
  localparam int PAYLOAD_W  = 16;

  localparam logic [BUS_AW-1:0] SEL_FRAME = 2'd0;
  localparam logic [BUS_AW-1:0] SEL_DIV   = 2'd1;
  localparam logic [BUS_AW-1:0] SEL_EVENT = 2'd2;
  localparam logic [BUS_AW-1:0] SEL_MASK  = 2'd3;

  localparam logic [1:0] OPC_WRITE = 2'b01;
  localparam logic [1:0] OPC_READ  = 2'b10;

  typedef struct packed {
    logic [1:0]           start_code;
    logic [1:0]           opcode;
    logic [4:0]           phy_sel;
    logic [4:0]           reg_sel;
    logic [1:0]           turn_code;
    logic [PAYLOAD_W-1:0] payload;
  } mgmt_word_t;
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_period,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = run && (cnt_q == half_period - 1'b1);
  assign rise_tick = wrap && !mdc;
  assign fall_tick = wrap && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
      mdc   <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      mdc   <= ~mdc;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [WORD_W-1:0]    frame_word,
  input  logic                 rise_tick,
  input  logic                 fall_tick,
  input  logic                 mdio_i,
  output logic                 busy,
  output logic                 mdio_o,
  output logic                 mdio_oe,
  output logic                 done_pulse,
  output logic                 rd_capture,
  output logic [PAYLOAD_W-1:0] rd_data
);
  localparam int TOTAL   = PRE_LEN + WORD_W;
  localparam int IDX_W   = $clog2(TOTAL);
  localparam int REL_POS = PRE_LEN + 15;
  localparam int DAT_POS = PRE_LEN + 16;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL - 1);
  localparam logic [IDX_W-1:0] REL_IDX  = IDX_W'(REL_POS);
  localparam logic [IDX_W-1:0] DAT_IDX  = IDX_W'(DAT_POS);

  logic [TOTAL-1:0]     shreg_q;
  logic [IDX_W-1:0]     idx_q;
  logic [IDX_W-1:0]     idx_nx;
  logic                 rd_op_q;
  logic [PAYLOAD_W-1:0] rd_sh_q;
  mgmt_word_t           fw;

  assign fw         = mgmt_word_t'(frame_word);
  assign idx_nx     = idx_q + 1'b1;
  assign done_pulse = busy && fall_tick && (idx_q == LAST_IDX);
  assign rd_capture = done_pulse && rd_op_q;
  assign rd_data    = rd_sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
      shreg_q <= '0;
      idx_q   <= '0;
      rd_op_q <= 1'b0;
      rd_sh_q <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        shreg_q <= {{PRE_LEN{1'b1}}, frame_word};
        idx_q   <= '0;
        mdio_o  <= 1'b1;
        mdio_oe <= 1'b1;
        rd_op_q <= (fw.opcode == OPC_READ);
      end
    end else begin
      if (rise_tick && rd_op_q && (idx_q >= DAT_IDX))
        rd_sh_q <= {rd_sh_q[PAYLOAD_W-2:0], mdio_i};
      if (fall_tick) begin
        if (idx_q == LAST_IDX) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b0;
          mdio_oe <= 1'b0;
        end else begin
          idx_q   <= idx_nx;
          shreg_q <= {shreg_q[TOTAL-2:0], 1'b0};
          mdio_o  <= shreg_q[TOTAL-2];
          mdio_oe <= !(rd_op_q && (idx_nx >= REL_IDX));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_reg_file.sv
module mdio_reg_file
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [BUS_AW-1:0]    bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  input  logic                 busy,
  input  logic                 done_pulse,
  input  logic                 rd_capture,
  input  logic [PAYLOAD_W-1:0] rd_data,
  output logic                 start,
  output logic [DIV_W-1:0]     div_q,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic                 ev_done,
  output logic                 mask_done,
  output logic                 irq
);
  logic [WORD_W-1:0] frame_q;
  logic              wr_frame, wr_div, wr_event, wr_mask;
  logic              ev_nxt, mask_nxt;

  assign wr_frame = bus_wr && (bus_addr == SEL_FRAME);
  assign wr_div   = bus_wr && (bus_addr == SEL_DIV);
  assign wr_event = bus_wr && (bus_addr == SEL_EVENT);
  assign wr_mask  = bus_wr && (bus_addr == SEL_MASK);
  assign start    = wr_frame && !busy && (div_q != '0);

  assign ev_nxt   = (ev_done && !(wr_event && bus_wdata[0])) || done_pulse;
  assign mask_nxt = wr_mask ? bus_wdata[0] : mask_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q   <= '0;
      div_q     <= '0;
      ev_done   <= 1'b0;
      mask_done <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (wr_frame && !busy)
        frame_q <= bus_wdata;
      else if (rd_capture)
        frame_q[PAYLOAD_W-1:0] <= rd_data;
      if (wr_div)
        div_q <= bus_wdata[DIV_W-1:0];
      ev_done   <= ev_nxt;
      mask_done <= mask_nxt;
      irq       <= ev_nxt && mask_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        SEL_FRAME: bus_rdata <= frame_q;
        SEL_DIV:   bus_rdata <= WORD_W'(div_q);
        SEL_EVENT: bus_rdata <= WORD_W'(ev_done);
        default:   bus_rdata <= WORD_W'(mask_done);
      endcase
    end
  end
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W   = 8,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i,
  output logic              irq
);
  logic                 busy, start, done_pulse, rd_capture;
  logic                 rise_tick, fall_tick;
  logic                 ev_done, mask_done;
  logic [DIV_W-1:0]     div_q;
  logic [PAYLOAD_W-1:0] rd_data;

  mdio_reg_file #(.DIV_W(DIV_W)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .busy(busy),
    .done_pulse(done_pulse), .rd_capture(rd_capture), .rd_data(rd_data),
    .start(start), .div_q(div_q), .bus_rdata(bus_rdata),
    .ev_done(ev_done), .mask_done(mask_done), .irq(irq)
  );

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk(clk), .rst(rst), .run(busy), .half_period(div_q),
    .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN)) u_eng (
    .clk(clk), .rst(rst), .start(start), .frame_word(bus_wdata),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .mdio_i(mdio_i),
    .busy(busy), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .done_pulse(done_pulse), .rd_capture(rd_capture), .rd_data(rd_data)
  );
endmodule

// File: rtl/mdio_mgmt_chk.sv
module mdio_mgmt_chk (
  input logic clk,
  input logic rst,
  input logic mdc,
  input logic mdio_o,
  input logic mdio_oe,
  input logic irq,
  input logic busy,
  input logic done_pulse,
  input logic ev_done,
  input logic mask_done
);
  // R1
  mdo_hold_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    mdc |-> $stable(mdio_o));
  // R2
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);
  // R4
  oe_only_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mdio_oe |-> busy);
  // R5
  done_release_chk: assert property (@(posedge clk) disable iff (rst)
    done_pulse |=> (!busy && !mdc && !mdio_oe && ev_done));
  // R7
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (ev_done && mask_done));
endmodule

bind mdio_mgmt_ctrl mdio_mgmt_chk u_chk (
  .clk(clk), .rst(rst), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
  .irq(irq), .busy(busy), .done_pulse(done_pulse),
  .ev_done(ev_done), .mask_done(mask_done)
);

// File: tb/tb_mdio_mgmt_ctrl.sv
module tb_mdio_mgmt_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        mdc, mdio_o, mdio_oe, irq;
  logic        mdio_i = 1'b0;

  int n_chk = 0, n_fail = 0;
  bit started = 0;

  // behavioural reference state
  bit          m_busy, m_rd, m_ev, m_mask, m_rd_pend;
  int          m_p, m_n;
  logic [63:0] m_f64;
  logic [31:0] m_frame, m_rdata;
  logic [7:0]  m_div;
  logic [15:0] phy_word = 16'h0;

  mdio_mgmt_ctrl dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i),
    .irq(irq)
  );

  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h exp %h at %0t", tag, got, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    bit was_busy, done, clr;
    started = 1;
    if (rst) begin
      m_busy = 0; m_rd = 0; m_ev = 0; m_mask = 0; m_rd_pend = 0;
      m_p = 0; m_n = 1; m_f64 = '0; m_frame = '0; m_rdata = '0; m_div = '0;
    end else begin
      m_rd_pend = bus_rd;
      if (bus_rd)
        case (bus_addr)
          2'd0: m_rdata = m_frame;
          2'd1: m_rdata = {24'd0, m_div};
          2'd2: m_rdata = {31'd0, m_ev};
          default: m_rdata = {31'd0, m_mask};
        endcase
      was_busy = m_busy; done = 0;
      clr = bus_wr && bus_addr == 2'd2 && bus_wdata[0];
      if (was_busy) begin
        m_p++;
        if (m_p == 128 * m_n) begin
          m_busy = 0; done = 1;
          if (m_rd) m_frame[15:0] = phy_word;
        end
      end else if (bus_wr && bus_addr == 2'd0) begin
        m_frame = bus_wdata;
        if (m_div != 0) begin
          m_busy = 1; m_p = 0; m_n = m_div;
          m_rd = (bus_wdata[29:28] == 2'b10);
          m_f64 = {32'hFFFF_FFFF, bus_wdata};
        end
      end
      if (bus_wr && bus_addr == 2'd1) m_div = bus_wdata[7:0];
      if (bus_wr && bus_addr == 2'd3) m_mask = bus_wdata[0];
      m_ev = (m_ev && !clr) || done;
    end
  end

  always @(negedge clk) begin
    int b;
    b = m_busy ? m_p / (2 * m_n) : 0;
    if (started) begin
      chk("R2 mdc", {31'd0, mdc}, {31'd0, m_busy && ((m_p % (2 * m_n)) >= m_n)});
      chk("R4 mdio_oe", {31'd0, mdio_oe}, {31'd0, m_busy && !(m_rd && b >= 47)});
      if (m_busy && mdio_oe)
        chk("R1 mdio_o", {31'd0, mdio_o}, {31'd0, m_f64[63-b]});
      chk("R7 irq", {31'd0, irq}, {31'd0, m_ev && m_mask});
      if (m_rd_pend) chk("R10 rdata", bus_rdata, m_rdata);
    end
    if (m_busy && m_rd && b >= 48) mdio_i = phy_word[63-b];
    else mdio_i = m_p[0];
  end

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd_expect(input logic [1:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0;
    chk(tag, bus_rdata, e);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  function automatic logic [31:0] mk(input logic [1:0] op, input logic [4:0] pa,
                                     input logic [4:0] ra, input logic [15:0] d);
    return {2'b01, op, pa, ra, 2'b10, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL R5 watchdog got timeout exp completion");
    finish_run();
  end

  initial begin
    logic [31:0] w;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 mdc", {31'd0, mdc}, 32'd0);
    chk("R11 oe", {31'd0, mdio_oe}, 32'd0);
    chk("R11 irq", {31'd0, irq}, 32'd0);
    rd_expect(2'd0, 32'd0, "R11 frame");
    rd_expect(2'd1, 32'd0, "R11 div");
    rd_expect(2'd2, 32'd0, "R11 event");
    rd_expect(2'd3, 32'd0, "R11 mask");

    // R8 divider zero blocks frames
    w = mk(2'b01, 5'd3, 5'd9, 16'h1234);
    bus_write(2'd0, w);
    repeat (20) @(negedge clk);
    chk("R8 mdc", {31'd0, mdc}, 32'd0);
    rd_expect(2'd0, w, "R8 frame stored");
    rd_expect(2'd2, 32'd0, "R8 no event");

    // R3 write frame, N=2, mask on
    bus_write(2'd1, 32'd2);
    bus_write(2'd3, 32'd1);
    w = mk(2'b01, 5'd5, 5'd3, 16'hA5C3);
    bus_write(2'd0, w);
    repeat (256 + 4) @(negedge clk);
    rd_expect(2'd2, 32'd1, "R5 event set");
    chk("R7 irq on", {31'd0, irq}, 32'd1);
    rd_expect(2'd0, w, "R3 frame kept");

    // R6 write-0 no effect, write-1 clears
    bus_write(2'd2, 32'd0);
    rd_expect(2'd2, 32'd1, "R6 write0 keeps");
    bus_write(2'd2, 32'd1);
    rd_expect(2'd2, 32'd0, "R6 write1 clears");

    // R4 read frame, N=1
    bus_write(2'd1, 32'd1);
    phy_word = 16'h3C5A;
    w = mk(2'b10, 5'd17, 5'd30, 16'hFFFF);
    bus_write(2'd0, w);
    repeat (128 + 4) @(negedge clk);
    rd_expect(2'd0, {w[31:16], 16'h3C5A}, "R4 read data");
    bus_write(2'd2, 32'd1);

    // R9 write during frame dropped, N=3
    bus_write(2'd1, 32'd3);
    phy_word = 16'h8E71;
    w = mk(2'b10, 5'd1, 5'd2, 16'h0000);
    bus_write(2'd0, w);
    repeat (100) @(negedge clk);
    bus_write(2'd0, mk(2'b01, 5'd31, 5'd31, 16'h5555));
    repeat (384) @(negedge clk);
    rd_expect(2'd0, {w[31:16], 16'h8E71}, "R9 frame untouched");
    rd_expect(2'd2, 32'd1, "R9 original frame done");
    bus_write(2'd2, 32'd1);

    // R6 clear on completion edge, mask off (R7 polling)
    bus_write(2'd1, 32'd1);
    bus_write(2'd3, 32'd0);
    bus_write(2'd0, mk(2'b01, 5'd2, 5'd4, 16'hC0DE));
    repeat (126) @(negedge clk);
    bus_write(2'd2, 32'd1);
    rd_expect(2'd2, 32'd1, "R6 set wins");
    chk("R7 masked irq", {31'd0, irq}, 32'd0);
    rd_expect(2'd1, 32'd1, "R10 div readback");
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule